// File: doc/BRIEF.md
# Stack Push/Pop Bus Sequencer

This block moves one 16-bit register to or from a stack held in byte-wide memory. A single-clock start request selects push or pop and supplies the word to store and the current program counter. The sequencer then runs four machine cycles of three T-states each. The first two machine cycles read the opcode byte and the following code byte at the program counter. The other two transfer the stack bytes.

A push steps the stack pointer down before each write. The high byte is written first, then the low byte. A pop reads the byte at the stack pointer into the low half of the result, then the byte one above it into the high half. The stack pointer moves up after each read. The block holds the stack pointer and program counter itself. It drives active-low memory request, read and write strobes, and it marks completion with a one-clock done pulse.

Top module: `stk_bus_seq`

## Requirements
- R1: An accepted operation keeps `busy_o` high for exactly 12 clocks: four machine cycles of three T-states each.
- R2: Machine cycles 1 and 2 are reads at the captured program counter and at that value plus one. After the operation, `pc_o` equals the captured value plus two, modulo 65536.
- R3: For a pop (`pop_sel_i`=1), machine cycle 3 reads at SP and cycle 4 reads at SP+1. The first byte read becomes `pop_word_o[7:0]` and the second becomes `pop_word_o[15:8]`. SP ends at its start value plus two.
- R4: For a push (`pop_sel_i`=0), machine cycle 3 writes `push_word_i[15:8]` at SP-1 and cycle 4 writes `push_word_i[7:0]` at SP-2. SP ends at its start value minus two.
- R5: In T-states 1 and 2 of every machine cycle, `mreq_n_o` is low. It is paired with `rd_n_o` low for fetches and pop reads, and with `wr_n_o` low for push writes. All strobes are high in T3 and while idle. `rd_n_o` and `wr_n_o` are never low together.
- R6: `addr_o` is stable over all three T-states of a machine cycle. `wr_data_o` is stable over the whole of a write cycle.
- R7: `done_o` is high for exactly the one clock after T3 of machine cycle 4. `pop_word_o` is valid from that clock and keeps its value until the next pop.
- R8: A start request made while busy is ignored: the running operation, the stack pointer and the program counter are not affected.
- R9: A start request made during the clock in which `done_o` is high is accepted, and machine cycle 1 begins on the next clock.
- R10: Stack pointer arithmetic wraps modulo 65536, so a push from 0x0000 stores at 0xFFFF and 0xFFFE.
- R11: A synchronous reset returns the block to idle with all strobes high, `done_o` low, and the stack pointer at its reset value (default 0x0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-clock request to start an operation |
| pop_sel_i | input | 1 | 1 = pop, 0 = push; sampled with the start request |
| push_word_i | input | 16 | Word to push; sampled with the start request |
| pc_i | input | 16 | Program counter for the two fetches; sampled with the start request |
| rd_data_i | input | 8 | Memory read data, sampled at the end of T3 |
| addr_o | output | 16 | Memory address |
| wr_data_o | output | 8 | Memory write data |
| mreq_n_o | output | 1 | Memory request strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-clock completion pulse |
| pop_word_o | output | 16 | Last popped word |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter after stepping |

## Verification
Two events can fall in the same clock. One is the completion of an operation (the done pulse together with the final stack-pointer step). The other is the acceptance of a new start request. The bench raises the next request exactly on the done clock. It then judges that done is already low, that machine cycle 1 of the new operation drives the new program counter with read strobes, and that the stack pointer continues from the value the first operation left. A second race is also tested: a request arriving mid-operation with the opposite push/pop select and a different program counter must leave the addresses, the final stack pointer and the idle state afterwards unchanged.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

   // Machine cycles of one push or pop, in bus order.
   typedef enum logic [1:0] {
      MC_FETCH_OP  = 2'd0,
      MC_FETCH_ARG = 2'd1,
      MC_STK_1     = 2'd2,
      MC_STK_2     = 2'd3
   } mcyc_e;

   localparam int unsigned MC_PER_OP = 4;
   localparam int unsigned BYTES_PER_WORD = 2;

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
   import stk_seq_pkg::*;
#(
   parameter int unsigned T_STATES = 3,
   parameter int unsigned TW       = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   output logic          busy_o,
   output logic          accept_o,
   output logic          mc_end_o,
   output logic          done_o,
   output mcyc_e         mc_o,
   output logic [TW-1:0] t_o
);

   localparam logic [TW-1:0] T_LAST = TW'(T_STATES - 1);

   logic          busy_q;
   logic          done_q;
   mcyc_e         mc_q;
   logic [TW-1:0] t_q;
   logic          t_last;

   assign t_last   = (t_q == T_LAST);
   assign accept_o = start_i & ~busy_q;
   assign mc_end_o = busy_q & t_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         mc_q   <= MC_FETCH_OP;
         t_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept_o) begin
            busy_q <= 1'b1;
            mc_q   <= MC_FETCH_OP;
            t_q    <= '0;
         end else if (busy_q) begin
            if (t_last) begin
               t_q <= '0;
               if (mc_q == MC_STK_2) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  mc_q <= mcyc_e'(mc_q + 2'd1);
               end
            end else begin
               t_q <= t_q + TW'(1);
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign mc_o   = mc_q;
   assign t_o    = t_q;

   AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q); // R7

   AST_T_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (t_q <= T_LAST)); // R1

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy_q && start_i && !(mc_end_o && mc_q == MC_STK_2))
      |=> !(mc_q == MC_FETCH_OP && t_q == '0)); // R8

endmodule

// File: rtl/stk_seq_sp.sv
module stk_seq_sp #(
   parameter int unsigned    AW     = 16,
   parameter logic [AW-1:0]  SP_RST = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_i,
   input  logic          pop_i,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] stk_addr_o
);

   logic [AW-1:0] sp_q;
   logic [AW-1:0] sp_dec;
   logic [AW-1:0] sp_inc;

   // Pre-decrement for push, post-increment for pop; both wrap.
   assign sp_dec     = sp_q - AW'(1);
   assign sp_inc     = sp_q + AW'(1);
   assign stk_addr_o = pop_i ? sp_q : sp_dec;

   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q <= SP_RST;
      end else if (step_i) begin
         sp_q <= pop_i ? sp_inc : sp_dec;
      end
   end

   assign sp_o = sp_q;

   AST_SP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
      step_i |=> ((sp_q == $past(sp_q) + AW'(1)) ||
                  (sp_q == $past(sp_q) - AW'(1)))); // R10

   AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(sp_q)); // R8

endmodule

// File: rtl/stk_seq_bus.sv
module stk_seq_bus
   import stk_seq_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 8,
   parameter int unsigned TW       = 2,
   parameter int unsigned T_STATES = 3
) (
   input  logic            busy_i,
   input  mcyc_e           mc_i,
   input  logic [TW-1:0]   t_i,
   input  logic            pop_i,
   input  logic [AW-1:0]   pc_i,
   input  logic [AW-1:0]   stk_addr_i,
   input  logic [2*DW-1:0] word_i,
   output logic [AW-1:0]   addr_o,
   output logic [DW-1:0]   dout_o,
   output logic            mreq_n_o,
   output logic            rd_n_o,
   output logic            wr_n_o
);

   localparam logic [TW-1:0] T_LAST = TW'(T_STATES - 1);

   logic is_fetch;
   logic is_write;
   logic strobe_win;

   assign is_fetch   = (mc_i == MC_FETCH_OP) || (mc_i == MC_FETCH_ARG);
   assign is_write   = busy_i & ~is_fetch & ~pop_i;
   assign strobe_win = busy_i & (t_i != T_LAST);

   always_comb begin
      addr_o = '0;
      if (busy_i) begin
         addr_o = is_fetch ? pc_i : stk_addr_i;
      end
   end

   // High byte leaves in the first stack cycle, low byte in the second.
   always_comb begin
      dout_o = '0;
      if (is_write) begin
         dout_o = (mc_i == MC_STK_1) ? word_i[2*DW-1:DW] : word_i[DW-1:0];
      end
   end

   assign mreq_n_o = ~strobe_win;
   assign rd_n_o   = ~(strobe_win & ~is_write);
   assign wr_n_o   = ~(strobe_win & is_write);

endmodule

// File: rtl/stk_bus_seq.sv
module stk_bus_seq
   import stk_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned T_STATES = 3,
   parameter logic [ADDR_W-1:0] SP_RST = '0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_i,
   input  logic                pop_sel_i,
   input  logic [2*DATA_W-1:0] push_word_i,
   input  logic [ADDR_W-1:0]   pc_i,
   input  logic [DATA_W-1:0]   rd_data_i,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   wr_data_o,
   output logic                mreq_n_o,
   output logic                rd_n_o,
   output logic                wr_n_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [2*DATA_W-1:0] pop_word_o,
   output logic [ADDR_W-1:0]   sp_o,
   output logic [ADDR_W-1:0]   pc_o
);

   localparam int unsigned WORD_W = BYTES_PER_WORD * DATA_W;
   localparam int unsigned TW     = (T_STATES > 1) ? $clog2(T_STATES) : 1;
   localparam logic [TW-1:0] T_LAST = TW'(T_STATES - 1);

   if (T_STATES < 2) begin : g_bad_tstates
      $error("stk_bus_seq: T_STATES must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("stk_bus_seq: ADDR_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("stk_bus_seq: DATA_W must be at least 1");
   end

   logic                busy;
   logic                accept;
   logic                mc_end;
   mcyc_e               mc;
   logic [TW-1:0]       t;
   logic                op_pop_q;
   logic [WORD_W-1:0]   word_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [ADDR_W-1:0]   stk_addr;
   logic                in_fetch;
   logic                sp_step;

   stk_seq_ctrl #(
      .T_STATES (T_STATES),
      .TW       (TW)
   ) ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .busy_o   (busy),
      .accept_o (accept),
      .mc_end_o (mc_end),
      .done_o   (done_o),
      .mc_o     (mc),
      .t_o      (t)
   );

   assign in_fetch = (mc == MC_FETCH_OP) || (mc == MC_FETCH_ARG);
   assign sp_step  = mc_end & ~in_fetch;

   // Operation attributes and program counter, latched at acceptance.
   always_ff @(posedge clk) begin
      if (rst) begin
         op_pop_q <= 1'b0;
         word_q   <= '0;
         pc_q     <= '0;
      end else if (accept) begin
         op_pop_q <= pop_sel_i;
         word_q   <= push_word_i;
         pc_q     <= pc_i;
      end else if (mc_end && in_fetch) begin
         pc_q     <= pc_q + ADDR_W'(1);
      end
   end

   stk_seq_sp #(
      .AW     (ADDR_W),
      .SP_RST (SP_RST)
   ) sp_i (
      .clk        (clk),
      .rst        (rst),
      .step_i     (sp_step),
      .pop_i      (op_pop_q),
      .sp_o       (sp_o),
      .stk_addr_o (stk_addr)
   );

   stk_seq_bus #(
      .AW       (ADDR_W),
      .DW       (DATA_W),
      .TW       (TW),
      .T_STATES (T_STATES)
   ) bus_i (
      .busy_i     (busy),
      .mc_i       (mc),
      .t_i        (t),
      .pop_i      (op_pop_q),
      .pc_i       (pc_q),
      .stk_addr_i (stk_addr),
      .word_i     (word_q),
      .addr_o     (addr_o),
      .dout_o     (wr_data_o),
      .mreq_n_o   (mreq_n_o),
      .rd_n_o     (rd_n_o),
      .wr_n_o     (wr_n_o)
   );

   // One capture register per result byte; byte b arrives in stack cycle b.
   for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_cap
      localparam mcyc_e CAP_MC = (b == 0) ? MC_STK_1 : MC_STK_2;
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            byte_q <= '0;
         end else if (mc_end && op_pop_q && (mc == CAP_MC)) begin
            byte_q <= rd_data_i;
         end
      end
      assign pop_word_o[b*DATA_W +: DATA_W] = byte_q;
   end

   assign busy_o = busy;
   assign pc_o   = pc_q;

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n_o && !wr_n_o)); // R5

   AST_LAST_T_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!busy || t == T_LAST) |-> (mreq_n_o && rd_n_o && wr_n_o)); // R5

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (busy && t != '0) |-> $stable(addr_o)); // R6

   AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      (busy && t != '0 && !wr_n_o) |-> $stable(wr_data_o)); // R6

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy && $past(busy))); // R7

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (mc_end && in_fetch) |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R2

endmodule

// File: tb/stk_bus_seq_tb.sv
module stk_bus_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        pop_sel = 1'b0;
   logic [15:0] push_word = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  rd_data;
   logic [15:0] addr_o;
   logic [7:0]  wr_data_o;
   logic        mreq_n_o, rd_n_o, wr_n_o, busy_o, done_o;
   logic [15:0] pop_word_o, sp_o, pc_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] sp_m = 16'h0000;
   logic [15:0] last_pop = 16'h0000;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Memory model: each address returns a fixed function of itself.
   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign rd_data = mem_f(addr_o);

   stk_bus_seq dut_i (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .pop_sel_i   (pop_sel),
      .push_word_i (push_word),
      .pc_i        (pc_in),
      .rd_data_i   (rd_data),
      .addr_o      (addr_o),
      .wr_data_o   (wr_data_o),
      .mreq_n_o    (mreq_n_o),
      .rd_n_o      (rd_n_o),
      .wr_n_o      (wr_n_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .pop_word_o  (pop_word_o),
      .sp_o        (sp_o),
      .pc_o        (pc_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic arm(input bit pop, input logic [15:0] w, input logic [15:0] pc);
      start     = 1'b1;
      pop_sel   = pop;
      push_word = w;
      pc_in     = pc;
   endtask

   // Called at a negedge. Walks all 12 T-states, ends at the done clock.
   task automatic run_op(input bit issue, input bit pop, input logic [15:0] w,
                         input logic [15:0] pc, input bit poke);
      logic [15:0] sp0;
      logic [15:0] ea;
      logic        ewr;
      logic [2:0]  estb;
      sp0 = sp_m;
      if (issue) arm(pop, w, pc);
      @(negedge clk);
      start = 1'b0;
      if (!issue) chk(addr_o == pc && done_o == 1'b0 && !rd_n_o, "R9", {addr_o, 7'd0, done_o, 7'd0, rd_n_o}, {pc, 16'h0000});
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 3; t++) begin
            case (m)
               0: ea = pc;
               1: ea = pc + 16'd1;
               2: ea = pop ? sp0 : sp0 - 16'd1;
               default: ea = pop ? sp0 + 16'd1 : sp0 - 16'd2;
            endcase
            ewr = (m >= 2) && !pop;
            chk(busy_o && !done_o, "R1", {busy_o, done_o}, 2'b10);
            chk(addr_o == ea, (m < 2) ? "R2" : (pop ? "R3" : "R4"), addr_o, ea);
            estb = (t < 2) ? {1'b0, ewr, !ewr} : 3'b111;
            chk({mreq_n_o, rd_n_o, wr_n_o} == estb, "R5", {mreq_n_o, rd_n_o, wr_n_o}, estb);
            if (ewr) chk(wr_data_o == ((m == 2) ? w[15:8] : w[7:0]), "R6", wr_data_o,
                         (m == 2) ? w[15:8] : w[7:0]);
            if (poke && m == 1 && t == 1) begin
               start = 1'b1; pop_sel = !pop; pc_in = 16'hDEAD;   // R8 stimulus
            end else if (poke) begin
               start = 1'b0;
            end
            @(negedge clk);
         end
      end
      sp_m = pop ? sp0 + 16'd2 : sp0 - 16'd2;
      chk(done_o && !busy_o, "R7", {done_o, busy_o}, 2'b10);
      if (pop) begin
         last_pop = {mem_f(sp0 + 16'd1), mem_f(sp0)};
         chk(pop_word_o == last_pop, "R3", pop_word_o, last_pop);
      end else begin
         chk(pop_word_o == last_pop, "R7", pop_word_o, last_pop);
      end
      chk(sp_o == sp_m, pop ? "R3" : "R4", sp_o, sp_m);
      chk(pc_o == pc + 16'd2, "R2", pc_o, pc + 16'd2);
   endtask

   // {pop, push word, program counter}; starts from SP = 0x0000.
   localparam logic [32:0] VEC [0:5] = '{
      {1'b0, 16'hA1B2, 16'h0100},   // push from 0x0000: wraps, R10
      {1'b0, 16'h3C4D, 16'h0200},
      {1'b1, 16'h0000, 16'h0300},
      {1'b1, 16'h0000, 16'hFFFF},   // pc wraps; SP reads 0xFFFE,0xFFFF
      {1'b1, 16'hFFFF, 16'h1234},
      {1'b0, 16'h0000, 16'h4000}
   };

   initial begin : wdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state
      chk({mreq_n_o, rd_n_o, wr_n_o} == 3'b111 && !busy_o && !done_o, "R11",
          {mreq_n_o, rd_n_o, wr_n_o, busy_o, done_o}, 5'b11100);
      chk(sp_o == 16'h0000 && pop_word_o == 16'h0000, "R11", {sp_o, pop_word_o}, 32'h0);

      foreach (VEC[i]) begin
         run_op(1'b1, VEC[i][32], VEC[i][31:16], VEC[i][15:0], 1'b0);
         if (i == 0) chk(sp_o == 16'hFFFE, "R10", sp_o, 16'hFFFE);
         if (i == 3) chk(sp_o == 16'h0000, "R10", sp_o, 16'h0000);
      end
      @(negedge clk);
      chk(!done_o && !busy_o, "R7", {done_o, busy_o}, 2'b00);

      // R8: request mid-operation with opposite select and other pc
      run_op(1'b1, 1'b0, 16'h5566, 16'h0800, 1'b1);
      @(negedge clk);
      chk(!busy_o && !done_o && mreq_n_o, "R8", {busy_o, done_o, mreq_n_o}, 3'b001);
      chk(sp_o == sp_m && pc_o == 16'h0802, "R8", {sp_o, pc_o}, {sp_m, 16'h0802});

      // R9: next request raised during the done clock
      run_op(1'b1, 1'b1, 16'h0000, 16'h0900, 1'b0);
      arm(1'b0, 16'h7788, 16'h0A00);
      run_op(1'b0, 1'b0, 16'h7788, 16'h0A00, 1'b0);
      @(negedge clk);

      // R11: reset in the middle of an operation
      arm(1'b1, 16'h0000, 16'h0C00);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk({mreq_n_o, rd_n_o, wr_n_o} == 3'b111 && !busy_o && !done_o, "R11",
          {mreq_n_o, rd_n_o, wr_n_o, busy_o, done_o}, 5'b11100);
      chk(sp_o == 16'h0000, "R11", sp_o, 16'h0000);
      rst = 1'b0;
      sp_m = 16'h0000;
      last_pop = 16'h0000;
      @(negedge clk);
      run_op(1'b1, 1'b1, 16'h0000, 16'h0D00, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule